// File: doc/BRIEF.md
# Reset Cause Capture Register

This block records which reset sources fired since the register was last read. It keeps five sticky cause flags: power-on, hardware standby, watchdog expiry, external reset pin and software reset request. Each source delivers a one-cycle pulse. The pulse sets its own flag and leaves the other four flags unchanged. The block's asynchronous reset is the power-on indication. Releasing it leaves only the power-on flag set.

Software reads the flags as the upper five bits of an 8-bit read-only register, using a simple read strobe. Read data is combinational, so the value returned during the strobe cycle is the value before the clear. All flags clear on the clock edge that ends the strobe cycle. Bit 2 of the register always reads 1. The two lowest bits mirror the interval-select field of the neighbouring watchdog control logic.

After power-on, a real system leaves the non-power-on flags undefined, so software must ignore them whenever the power-on flag is 1. This model clears them to 0 so that simulation is deterministic.

Top module: `rst_cause_reg`

## Requirements
- R1: Read data bits 7..3 hold the flags for power-on, standby, watchdog, external pin and software, in that order from bit 7 down. The pulse inputs map to them as cause_evt_i[4]=power-on, [3]=standby, [2]=watchdog, [1]=external, [0]=software.
- R2: After rst_n is released and before any pulse or read, the read data is 1000_0 in bits 7..3.
- R3: A pulse on cause_evt_i[k] sets flag k at the next rising clock edge. Every flag whose pulse is low keeps its previous value.
- R4: While rd_stb_i is high, the read data shows the flags as they stood before the clear. At the next rising edge, every flag whose pulse is low becomes 0.
- R5: When a cause pulse and rd_stb_i occur in the same cycle, that cause's flag is 1 after the edge.
- R6: Read data bit 2 is always 1.
- R7: Read data bits 1..0 always equal wd_sel_i.
- R8: With no pulse and no read strobe, every flag holds its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cause_evt_i | input | 5 | One-cycle reset cause pulses, bit 4 power-on down to bit 0 software |
| rd_stb_i | input | 1 | Register read strobe; clears the flags at the end of the cycle |
| wd_sel_i | input | 2 | Watchdog interval-select field, shown in the low read bits |
| rdata_o | output | 8 | Register read data |

## Verification
The hardest case to reach from the ports is a read strobe that meets a set of cause pulses while the flags already hold an arbitrary earlier pattern. In that case, clear, set and hold all act in one edge.

The bench reaches any prior pattern in a single cycle by pulsing that pattern together with a read strobe. It then sweeps every prior pattern against every pulse pattern, with and without a strobe. In each case it checks the pre-clear read value, the post-edge value and the idle hold that follows.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  // Cause positions inside the flag vector (MSB = power-on).
  localparam int unsigned CAUSE_N   = 5;
  localparam int unsigned IDX_SW    = 0;
  localparam int unsigned IDX_EXT   = 1;
  localparam int unsigned IDX_WDOG  = 2;
  localparam int unsigned IDX_STBY  = 3;
  localparam int unsigned IDX_PON   = 4;
endpackage

// File: rtl/rst_cause_bit.sv
// One sticky flag: set has priority over clear.
module rst_cause_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/rst_cause_bank.sv
// Bank of sticky cause flags; only the power-on slot resets to 1.
module rst_cause_bank #(
  parameter int unsigned CAUSE_N = rst_cause_pkg::CAUSE_N,
  parameter int unsigned PON_IDX = rst_cause_pkg::IDX_PON
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_N-1:0] set_i,
  input  logic               clr_all_i,
  output logic [CAUSE_N-1:0] flags_o
);
  for (genvar i = 0; i < CAUSE_N; i++) begin : g_flag
    localparam logic RV = (i == PON_IDX) ? 1'b1 : 1'b0;
    rst_cause_bit #(.RST_VAL(RV)) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_i[i]),
      .clr_i (clr_all_i),
      .q_o   (flags_o[i])
    );
  end
endmodule

// File: rtl/rst_cause_view.sv
// Assembles the read word: flags, a constant-one bit, watchdog select.
module rst_cause_view #(
  parameter int unsigned CAUSE_N = rst_cause_pkg::CAUSE_N,
  parameter int unsigned WDSEL_W = 2,
  localparam int unsigned DATA_W = CAUSE_N + 1 + WDSEL_W
) (
  input  logic [CAUSE_N-1:0] flags_i,
  input  logic [WDSEL_W-1:0] wd_sel_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = {flags_i, 1'b1, wd_sel_i};
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int unsigned CAUSE_N = rst_cause_pkg::CAUSE_N,
  parameter int unsigned WDSEL_W = 2,
  localparam int unsigned DATA_W = CAUSE_N + 1 + WDSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_N-1:0] cause_evt_i,
  input  logic               rd_stb_i,
  input  logic [WDSEL_W-1:0] wd_sel_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [CAUSE_N-1:0] flags;

  rst_cause_bank #(.CAUSE_N(CAUSE_N), .PON_IDX(CAUSE_N-1)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (cause_evt_i),
    .clr_all_i (rd_stb_i),
    .flags_o   (flags)
  );

  rst_cause_view #(.CAUSE_N(CAUSE_N), .WDSEL_W(WDSEL_W)) u_view (
    .flags_i  (flags),
    .wd_sel_i (wd_sel_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int unsigned CAUSE_N = 5,
  parameter int unsigned WDSEL_W = 2,
  localparam int unsigned DATA_W = CAUSE_N + 1 + WDSEL_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CAUSE_N-1:0] cause_evt_i,
  input logic               rd_stb_i,
  input logic [WDSEL_W-1:0] wd_sel_i,
  input logic [DATA_W-1:0]  rdata_o
);
  logic [CAUSE_N-1:0] vis;
  assign vis = rdata_o[DATA_W-1 -: CAUSE_N];

  // R3
  set_own_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cause_evt_i) |=> ((vis & $past(cause_evt_i)) == $past(cause_evt_i)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb_i && cause_evt_i == '0) |=> $stable(vis));

  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (vis == $past(cause_evt_i)));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && (|cause_evt_i)) |=> ((vis & $past(cause_evt_i)) != '0));

  // R6
  fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[WDSEL_W] == 1'b1);

  // R7
  wdsel_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[WDSEL_W-1:0] == wd_sel_i);
endmodule

bind rst_cause_reg rst_cause_chk #(.CAUSE_N(CAUSE_N), .WDSEL_W(WDSEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cause_evt_i (cause_evt_i),
  .rd_stb_i    (rd_stb_i),
  .wd_sel_i    (wd_sel_i),
  .rdata_o     (rdata_o)
);

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
  logic       clk;
  logic       rst_n;
  logic [4:0] evt;
  logic       rd;
  logic [1:0] sel;
  logic [7:0] rdata;
  int         n_run;
  int         n_fail;
  logic [4:0] model;

  rst_cause_reg u0 (
    .clk(clk), .rst_n(rst_n), .cause_evt_i(evt), .rd_stb_i(rd),
    .wd_sel_i(sel), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and check the read word before the rising edge.
  task automatic step(input logic [4:0] e, input logic r, input logic [1:0] s, input string tag);
    @(negedge clk);
    evt = e; rd = r; sel = s;
    #1;
    chk(tag, rdata, {model, 1'b1, s});
    model = (r ? 5'b0 : model) | e;
  endtask

  initial begin : watchdog
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; evt = '0; rd = 1'b0; sel = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model = 5'b10000;
    #1;
    // R2 R1 R6 R7: reset view, power-on flag only
    chk("R2 reset value", rdata, 8'b1000_0_1_11);
    step(5'b0, 1'b0, 2'b01, "R8 idle after reset");
    step(5'b0, 1'b0, 2'b10, "R8 idle after reset");
    // R1: each cause lands on its own bit
    for (int k = 0; k < 5; k++) begin
      step(5'b0, 1'b1, 2'b00, "R4 clear");
      step(5'b1 << k, 1'b0, 2'b00, "R1 idle");
      @(negedge clk); evt = '0; rd = 1'b0; #1;
      chk("R1 bit position", rdata, {5'b1 << k, 3'b100});
    end
    step(5'b0, 1'b0, 2'b00, "R8 idle");
    // Sweep: prior pattern p, event pattern e, read r
    for (int p = 0; p < 32; p++) begin
      for (int e = 0; e < 32; e++) begin
        for (int r = 0; r < 2; r++) begin
          step(5'(p), 1'b1, 2'(e), "R8/R4 preload");
          step(5'(e), r[0], 2'(p), r ? "R4 pre-clear read" : "R3 set cycle");
          step(5'b0, 1'b0, 2'(e + p), r ? "R5 set over clear" : "R3 set and hold");
        end
      end
    end
    step(5'b0, 1'b0, 2'b01, "R8 final idle");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule